// File: doc/BRIEF.md
# Pointer-Addressed Packet Buffer Port

This block holds the packet page memory, four pages of 2048 bytes each. It gives a host byte-wide access to that memory through a sixteen-bit pointer register and a four-byte data window. The host loads the pointer one byte at a time. After that, every read or write through the window reaches one byte of one page.

The top pointer bit chooses the page. One setting takes the page from the packet-number register. The other setting takes the page at the head of the receive queue. Both page numbers come in as inputs, because allocation and queue handling live in a neighbouring block.

In step mode the pointer advances after each window access. In window mode the pointer stays put, and the window byte offset is added to the pointer offset. Reads are combinational.

Top module: `pbp_port`

## Requirements
- R1: After reset the pointer is 0x0000, so reads of host offsets 0 and 1 return 0x00.
- R2: A write to host offset 0 loads pointer bits 7:0 and a write to offset 1 loads bits 15:8. A read of offset 0 returns bits 7:0. A read of offset 1 returns bits 15:8 ANDed with 0xF7, so bit 3 of that byte always reads as 0.
- R3: With pointer bit 15 at 0, window accesses target page `pkt_num_i`. With it at 1, they target page `rx_head_i`.
- R4: With pointer bit 14 at 0, a window access at host offset 4+k (k = 0..3) reaches byte (pointer[10:0] + k) of the page, and the pointer keeps its value.
- R5: With pointer bit 14 at 1, a window access reaches byte pointer[10:0] whatever k is. On the next clock, bits 10:0 advance by one modulo 2048 and bits 15:11 stay the same.
- R6: Byte offsets wrap inside the selected page. In window mode, 2047 + 2 reaches byte 1. In step mode the pointer steps from 2047 to 0.
- R7: `rdata_o` carries the addressed byte in the same cycle as `rd_en_i`, and it is 0x00 whenever `rd_en_i` is low.
- R8: Writes to host offsets 2 and 3 have no effect. Reads of those offsets return 0x00.
- R9: A write to one page leaves the same byte offset of every other page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host byte write strobe |
| rd_en_i | input | 1 | Host byte read strobe |
| addr_i | input | 3 | Host offset: 0/1 pointer halves, 4..7 data window |
| wdata_i | input | 8 | Host write byte |
| pkt_num_i | input | 2 | Page held in the packet-number register |
| rx_head_i | input | 2 | Page at the head of the receive queue |
| rdata_o | output | 8 | Host read byte |

## Verification
The hardest cases to reach are the two offset wraps at the end of a page, in step mode and in window mode. The stimulus sets bits 15:11 to a non-zero pattern, loads the offset near 2047, and steps across the page edge. It then reads back the pointer halves to confirm the upper bits survived. The wrapped bytes are read back through a freshly loaded pointer, which shows they landed at the start of the same page. A write to a second page at a matching offset shows that pages stay isolated.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int PTR_W      = 16;
  localparam int SRC_BIT    = 15;  // 1: receive-queue head page
  localparam int STEP_BIT   = 14;  // 1: step pointer after each window access
  localparam int HOST_AW    = 3;
  localparam logic [7:0] HI_RD_MASK = 8'hF7;

  typedef enum logic [HOST_AW-1:0] {
    HOST_PTR_LO = 3'd0,
    HOST_PTR_HI = 3'd1,
    HOST_RSV_A  = 3'd2,
    HOST_RSV_B  = 3'd3,
    HOST_WIN_0  = 3'd4,
    HOST_WIN_1  = 3'd5,
    HOST_WIN_2  = 3'd6,
    HOST_WIN_3  = 3'd7
  } host_off_e;
endpackage

// File: rtl/pbp_ptr_reg.sv
module pbp_ptr_reg
  import pbp_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [7:0]       wdata_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [OFS_W-1:0] ofs_next;

  assign ofs_next = ptr_q[OFS_W-1:0] + OFS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ld_lo_i) begin
      ptr_q[7:0] <= wdata_i;
    end else if (ld_hi_i) begin
      ptr_q[PTR_W-1:8] <= wdata_i;
    end else if (step_i) begin
      ptr_q[OFS_W-1:0] <= ofs_next;  // upper bits held
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen
  import pbp_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int OFS_W  = 11
) (
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [1:0]        lane_i,
  input  logic [PAGE_W-1:0] pkt_num_i,
  input  logic [PAGE_W-1:0] rx_head_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              step_mode_o
);
  assign step_mode_o = ptr_i[STEP_BIT];
  assign page_o      = ptr_i[SRC_BIT] ? rx_head_i : pkt_num_i;

  // sum truncates to OFS_W: wraps within the page
  always_comb begin
    if (step_mode_o) ofs_o = ptr_i[OFS_W-1:0];
    else             ofs_o = ptr_i[OFS_W-1:0] + OFS_W'(lane_i);
  end
endmodule

// File: rtl/pbp_page_mem.sv
module pbp_page_mem #(
  parameter int PAGE_W = 2,
  parameter int OFS_W  = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int LANES = 4;
  localparam int IDX_W = PAGE_W + OFS_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic [1:0]       lane;
  logic [7:0]       lane_rd [LANES];

  assign idx  = {page_i, ofs_i[OFS_W-1:2]};
  assign lane = ofs_i[1:0];

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (lane == 2'(b))) mem[idx] <= wdata_i;
    end
    assign lane_rd[b] = mem[idx];
  end

  assign rdata_o = lane_rd[lane];
endmodule

// File: rtl/pbp_port.sv
module pbp_port
  import pbp_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [PAGE_W-1:0] pkt_num_i,
  input  logic [PAGE_W-1:0] rx_head_i,
  output logic [7:0]        rdata_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic              step_mode;
  logic              win_hit, win_acc;
  logic [7:0]        mem_rd;
  host_off_e         off;

  assign off     = host_off_e'(addr_i);
  assign win_hit = addr_i[2];
  assign win_acc = win_hit && (wr_en_i || rd_en_i);

  pbp_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_lo_i (wr_en_i && off == HOST_PTR_LO),
    .ld_hi_i (wr_en_i && off == HOST_PTR_HI),
    .wdata_i (wdata_i),
    .step_i  (win_acc && step_mode),
    .ptr_o   (ptr_q)
  );

  pbp_addr_gen #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_agen (
    .ptr_i       (ptr_q),
    .lane_i      (addr_i[1:0]),
    .pkt_num_i   (pkt_num_i),
    .rx_head_i   (rx_head_i),
    .page_o      (page),
    .ofs_o       (ofs),
    .step_mode_o (step_mode)
  );

  pbp_page_mem #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_en_i && win_hit),
    .page_i  (page),
    .ofs_i   (ofs),
    .wdata_i (wdata_i),
    .rdata_o (mem_rd)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (rd_en_i) begin
      unique case (off)
        HOST_PTR_LO: rdata_o = ptr_q[7:0];
        HOST_PTR_HI: rdata_o = ptr_q[15:8] & HI_RD_MASK;
        HOST_RSV_A,
        HOST_RSV_B:  rdata_o = 8'h00;
        default:     rdata_o = mem_rd;
      endcase
    end
  end
endmodule

// File: rtl/pbp_port_chk.sv
module pbp_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [2:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic [15:0] ptr_i
);
  logic ptr_wr, win_acc;
  assign ptr_wr  = wr_en_i && (addr_i[2:1] == 2'b00);
  assign win_acc = addr_i[2] && (wr_en_i || rd_en_i);

  AST_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0) |=> ptr_i[7:0] == $past(wdata_i)); // R2

  AST_HI_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 3'd1) |-> rdata_o[3] == 1'b0); // R2

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_wr && !(win_acc && ptr_i[14])) |=> $stable(ptr_i)); // R4

  AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_acc && ptr_i[14]) |=>
      (ptr_i[10:0] == $past(ptr_i[10:0]) + 11'd1) &&
      (ptr_i[15:11] == $past(ptr_i[15:11]))); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == 8'h00); // R7

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[2:1] == 2'b01) |-> rdata_o == 8'h00); // R8
endmodule

bind pbp_port pbp_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ptr_i   (ptr_q)
);

// File: tb/pbp_port_tb.sv
`timescale 1ns/1ps
module pbp_port_tb;
  logic       clk_i = 0, rst_ni = 1, wr_en_i = 0, rd_en_i = 0;
  logic [2:0] addr_i = 0;
  logic [7:0] wdata_i = 0;
  logic [1:0] pkt_num_i = 0, rx_head_i = 0;
  logic [7:0] rdata_o;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_ptr = 16'h0000;
  logic [7:0]  m_mem [int];
  logic [7:0]  q_exp [$];
  string       q_tag [$];

  always #2.5 clk_i = ~clk_i;

  pbp_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .pkt_num_i(pkt_num_i),
    .rx_head_i(rx_head_i), .rdata_o(rdata_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_key(logic [2:0] a);
    logic [1:0]  pg;
    logic [10:0] of;
    pg = m_ptr[15] ? rx_head_i : pkt_num_i;
    of = m_ptr[14] ? m_ptr[10:0] : m_ptr[10:0] + 11'(a[1:0]);
    return int'(pg) * 2048 + int'(of);
  endfunction

  task automatic m_step(logic [2:0] a);
    if (a[2] && m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; wr_en_i = 1;
    if (a == 3'd0) m_ptr[7:0] = d;
    else if (a == 3'd1) m_ptr[15:8] = d;
    else if (a[2]) begin
      m_mem[m_key(a)] = d;
      m_step(a);
    end
    @(posedge clk_i); #1;
    wr_en_i = 0;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    logic [7:0] e;
    int k;
    @(posedge clk_i); #1;
    addr_i = a; rd_en_i = 1;
    if (a == 3'd0) e = m_ptr[7:0];
    else if (a == 3'd1) e = m_ptr[15:8] & 8'hF7;
    else if (!a[2]) e = 8'h00;
    else begin
      k = m_key(a);
      e = m_mem.exists(k) ? m_mem[k] : 8'h00;
    end
    q_exp.push_back(e);
    q_tag.push_back(tag);
    m_step(a);
    @(posedge clk_i); #1;
    rd_en_i = 0;
  endtask

  task automatic set_pages(logic [1:0] p, logic [1:0] r);
    @(posedge clk_i); #1;
    pkt_num_i = p; rx_head_i = r;
  endtask

  task automatic set_ptr(logic [15:0] v);
    wr(3'd0, v[7:0]);
    wr(3'd1, v[15:8]);
  endtask

  // monitor: scoreboard pop at mid-cycle
  always @(negedge clk_i) begin
    if (rd_en_i) begin
      if (q_exp.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: actual=%h expected=none", rdata_o);
      end else begin
        check(q_tag.pop_front(), rdata_o, q_exp.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    rd(3'd0, "R1 ptr lo");
    rd(3'd1, "R1 ptr hi");

    set_ptr(16'hFF34);
    rd(3'd1, "R2 hi masked");
    rd(3'd0, "R2 lo");

    set_pages(2'd1, 2'd2);
    set_ptr(16'h0010);
    wr(3'd4, 8'hA0); wr(3'd5, 8'hA1); wr(3'd6, 8'hA2); wr(3'd7, 8'hA3);
    rd(3'd6, "R4 lane 2");
    rd(3'd7, "R4 lane 3");
    rd(3'd0, "R4 ptr held");

    wr(3'd1, 8'h80);
    wr(3'd4, 8'hB0);
    rd(3'd4, "R3 rx head page");
    wr(3'd1, 8'h00);
    rd(3'd4, "R3 pkt num page");

    set_ptr(16'h5FFE);
    wr(3'd7, 8'hC0); wr(3'd4, 8'hC1); wr(3'd4, 8'hC2);
    rd(3'd0, "R5 lo after steps");
    rd(3'd1, "R5 upper kept");
    set_ptr(16'h5FFE);
    rd(3'd5, "R6 step 2046");
    rd(3'd5, "R6 step 2047");
    rd(3'd5, "R6 step wrap 0");

    set_ptr(16'h07FF);
    wr(3'd6, 8'hD0);
    rd(3'd6, "R6 window wrap");
    set_ptr(16'h0001);
    rd(3'd4, "R6 wrapped byte at 1");

    set_ptr(16'h0010);
    wr(3'd2, 8'h55); wr(3'd3, 8'h66);
    rd(3'd2, "R8 rsv a");
    rd(3'd3, "R8 rsv b");
    rd(3'd0, "R8 ptr untouched");

    set_pages(2'd0, 2'd2);
    wr(3'd4, 8'hE0);
    set_pages(2'd1, 2'd2);
    rd(3'd4, "R9 page 1 intact");
    set_pages(2'd3, 2'd2);
    wr(3'd1, 8'h80);
    rd(3'd4, "R9 page 2 intact");

    @(posedge clk_i); #1;
    addr_i = 3'd4;
    @(negedge clk_i);
    check("R7 idle zero", rdata_o, 8'h00);

    repeat (3) @(posedge clk_i);
    if (q_exp.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", q_exp.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule